// File: doc/BRIEF.md
# Motor Drive Fault Protection Unit

This block supervises a chopper-fed DC motor drive. On each valid sample strobe it takes digitised armature current, DC-link voltage, winding temperature and shaft speed and compares them with trip levels. The current, voltage and speed trip levels are computed from programmable rated values by fixed-point multipliers with 6 fraction bits. Temperature uses two absolute levels. A separate short-circuit input from an external fast comparator acts on the gate-disable output without going through the sampled path.

Every detected fault is latched in a sticky status vector. The latched faults drive graded responses: gate shutdown, controlled stop, zero-torque command and current derating. When several responses are pending, only the most severe one is asserted. An independent brake-resistor enable follows over-voltage with hysteresis. The drive controller reads the response outputs directly and uses the derated current limit as its current-loop clamp.

Top module: `drive_fault_guard`

## Requirements
- R1: While `sc_in` is high, `gate_off` is high in the same cycle, without waiting for a sample. At the next clock edge bit 0 of `fault_stat` latches.
- R2: A valid sample with |`i_arm`| >= (`rated_cur`*112)>>6 sets bit 1 of `fault_stat` at the next edge and asserts `gate_off`.
- R3: A valid sample with `v_link` >= (`rated_volt`*77)>>6 sets bit 2 and turns `brake_on` on. `brake_on` turns off only on a valid sample with `v_link` < (`rated_volt`*74)>>6. Samples between the two levels leave it unchanged. `fault_clr` does not affect it.
- R4: A valid sample with `v_link` < (`rated_volt`*51)>>6 sets bit 3 and requests a controlled stop (`stop_req`).
- R5: A valid sample with `temp` >= 85 sets bit 4. While bit 4 is set, `cur_lim` equals (`rated_cur`*48)>>6; otherwise `cur_lim` equals `rated_cur`. Bit 4 asserts `derate`.
- R6: A valid sample with `temp` >= 125 sets bit 5 and requests a controlled stop.
- R7: A valid sample with |`speed`| >= (`rated_spd`*77)>>6 sets bit 6 and asserts `torque_zero`.
- R8: A status bit stays set until `fault_clr` is high in a cycle where its condition is absent. For a sampled fault, "absent" means absent in the sample of that cycle, or else in the latest valid sample. For bit 0, it means `sc_in` is low. A new detection in the same cycle wins over the clear.
- R9: At most one of `gate_off`, `stop_req`, `torque_zero`, `derate` is high, in that priority order. `act_code` is 4, 3, 2, 1 for these responses and 0 when none is pending.
- R10: Samples presented while `smp_valid` is low set no status bit and do not change `brake_on`.
- R11: After reset, `fault_stat` is zero, all response outputs are low, `act_code` is 0 and `cur_lim` equals `rated_cur`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe for the four measurements |
| i_arm | input | DW | Armature current, signed |
| v_link | input | DW | DC-link voltage, unsigned |
| temp | input | TW | Temperature in °C, signed |
| speed | input | DW | Shaft speed, signed |
| rated_cur | input | DW | Rated current |
| rated_volt | input | DW | Nominal DC-link voltage |
| rated_spd | input | DW | Rated speed |
| sc_in | input | 1 | Fast short-circuit comparator output |
| fault_clr | input | 1 | Request to clear latched faults |
| fault_stat | output | 7 | Sticky fault vector (bit map in R1 to R7) |
| gate_off | output | 1 | Gate shutdown |
| stop_req | output | 1 | Controlled stop request |
| torque_zero | output | 1 | Force torque command to zero |
| derate | output | 1 | Derated operation |
| brake_on | output | 1 | Brake resistor enable |
| cur_lim | output | DW | Current limit for the current loop |
| act_code | output | 3 | Dominant response code |

## Verification
The bench drives mostly nominal samples with random excursions across every trip level. It mixes in random strobe gaps, short-circuit pulses and clear requests, which exposes errors in the clear-versus-live rule and in the priority resolution when several faults are pending. Directed sequences separate the cases that random stimulus rarely isolates. One walks the DC-link voltage through the band between the brake release and trip levels, which shows whether hysteresis is held. Another applies a clear while the fault persists, which shows whether stickiness depends on the live condition. Others apply an over-range sample without a strobe, and a short-circuit pulse with no sample.

// File: rtl/dfg_pkg.sv
package dfg_pkg;
   localparam int NF    = 7;
   localparam int F_SC  = 0;
   localparam int F_OC  = 1;
   localparam int F_OV  = 2;
   localparam int F_UV  = 3;
   localparam int F_OTW = 4;
   localparam int F_OTH = 5;
   localparam int F_OS  = 6;

   localparam int NTHR  = 6;
   localparam int T_OC  = 0;
   localparam int T_OV  = 1;
   localparam int T_UV  = 2;
   localparam int T_OS  = 3;
   localparam int T_REL = 4;
   localparam int T_DER = 5;

   typedef enum logic [2:0] {
      ACT_NONE   = 3'd0,
      ACT_DERATE = 3'd1,
      ACT_TZERO  = 3'd2,
      ACT_STOP   = 3'd3,
      ACT_GATE   = 3'd4
   } act_e;
endpackage

// File: rtl/dfg_scale.sv
module dfg_scale #(
   parameter int DW   = 12,
   parameter int FRAC = 6,
   parameter int K    = 64
) (
   input  logic [DW-1:0] rated,
   output logic [DW:0]   thr
);
   localparam int PW = DW + FRAC + 2;

   generate
      if (K <= 0 || K >= (2 ** (FRAC + 1))) begin : g_bad_k
         $error("dfg_scale: factor K out of range");
      end
   endgenerate

   logic [PW-1:0] prod;
   assign prod = PW'(rated) * PW'(K);
   assign thr  = (DW+1)'(prod >> FRAC);
endmodule

// File: rtl/dfg_latch.sv
module dfg_latch #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] live,
   input  logic         clr,
   output logic [N-1:0] stat
);
   generate
      for (genvar b = 0; b < N; b++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               stat[b] <= 1'b0;
            else if (set[b])
               stat[b] <= 1'b1;
            else if (clr && !live[b])
               stat[b] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/dfg_brake.sv
module dfg_brake (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_valid,
   input  logic over,
   input  logic below_rel,
   output logic brake_on
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         brake_on <= 1'b0;
      else if (smp_valid) begin
         if (over)
            brake_on <= 1'b1;
         else if (below_rel)
            brake_on <= 1'b0;
      end
   end
endmodule

// File: rtl/dfg_grade.sv
module dfg_grade
   import dfg_pkg::*;
(
   input  logic [NF-1:0] stat,
   input  logic          sc_now,
   output logic          gate_off,
   output logic          stop_req,
   output logic          torque_zero,
   output logic          derate,
   output act_e          act
);
   logic want_gate, want_stop, want_tz, want_der;

   assign want_gate = sc_now | stat[F_SC] | stat[F_OC];
   assign want_stop = stat[F_UV] | stat[F_OTH];
   assign want_tz   = stat[F_OS];
   assign want_der  = stat[F_OTW];

   always_comb begin
      act = ACT_NONE;
      if (want_gate)      act = ACT_GATE;
      else if (want_stop) act = ACT_STOP;
      else if (want_tz)   act = ACT_TZERO;
      else if (want_der)  act = ACT_DERATE;
   end

   assign gate_off    = (act == ACT_GATE);
   assign stop_req    = (act == ACT_STOP);
   assign torque_zero = (act == ACT_TZERO);
   assign derate      = (act == ACT_DERATE);
endmodule

// File: rtl/drive_fault_guard.sv
module drive_fault_guard
   import dfg_pkg::*;
#(
   parameter int DW     = 12,
   parameter int TW     = 10,
   parameter int FRAC   = 6,
   parameter int OC_K   = 112,
   parameter int OV_K   = 77,
   parameter int UV_K   = 51,
   parameter int OS_K   = 77,
   parameter int REL_K  = 74,
   parameter int DER_K  = 48,
   parameter int T_WARN = 85,
   parameter int T_HOT  = 125
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_valid,
   input  logic signed [DW-1:0] i_arm,
   input  logic [DW-1:0]        v_link,
   input  logic signed [TW-1:0] temp,
   input  logic signed [DW-1:0] speed,
   input  logic [DW-1:0]        rated_cur,
   input  logic [DW-1:0]        rated_volt,
   input  logic [DW-1:0]        rated_spd,
   input  logic                 sc_in,
   input  logic                 fault_clr,
   output logic [NF-1:0]        fault_stat,
   output logic                 gate_off,
   output logic                 stop_req,
   output logic                 torque_zero,
   output logic                 derate,
   output logic                 brake_on,
   output logic [DW-1:0]        cur_lim,
   output logic [2:0]           act_code
);
   localparam int KTAB [NTHR] = '{OC_K, OV_K, UV_K, OS_K, REL_K, DER_K};
   localparam int STAB [NTHR] = '{0, 1, 1, 2, 1, 0};
   localparam logic signed [TW-1:0] TWARN_S = TW'(T_WARN);
   localparam logic signed [TW-1:0] THOT_S  = TW'(T_HOT);

   generate
      if (DW < 4 || TW < 2) begin : g_bad_w
         $error("drive_fault_guard: widths too small");
      end
      if (T_WARN >= T_HOT || T_HOT >= (2 ** (TW - 1))) begin : g_bad_t
         $error("drive_fault_guard: temperature levels inconsistent");
      end
      if (REL_K >= OV_K || UV_K >= REL_K) begin : g_bad_v
         $error("drive_fault_guard: voltage levels out of order");
      end
   endgenerate

   logic [2:0][DW-1:0] rsrc;
   logic [DW:0]        thr [NTHR];
   assign rsrc = {rated_spd, rated_volt, rated_cur};

   generate
      for (genvar g = 0; g < NTHR; g++) begin : g_thr
         dfg_scale #(.DW(DW), .FRAC(FRAC), .K(KTAB[g])) u_scale (
            .rated (rsrc[STAB[g]]),
            .thr   (thr[g])
         );
      end
   endgenerate

   logic [DW-1:0] i_mag, s_mag;
   assign i_mag = i_arm[DW-1] ? DW'(-i_arm) : DW'(i_arm);
   assign s_mag = speed[DW-1] ? DW'(-speed) : DW'(speed);

   logic [NF-1:0] cond;
   logic          below_rel;
   always_comb begin
      cond        = '0;
      cond[F_OC]  = {1'b0, i_mag}  >= thr[T_OC];
      cond[F_OV]  = {1'b0, v_link} >= thr[T_OV];
      cond[F_UV]  = {1'b0, v_link} <  thr[T_UV];
      cond[F_OTW] = temp >= TWARN_S;
      cond[F_OTH] = temp >= THOT_S;
      cond[F_OS]  = {1'b0, s_mag}  >= thr[T_OS];
   end
   assign below_rel = {1'b0, v_link} < thr[T_REL];

   logic [NF-1:0] live_q, live_now, set_now;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         live_q <= '0;
      else if (smp_valid)
         live_q <= cond;
   end

   always_comb begin
      live_now       = smp_valid ? cond : live_q;
      live_now[F_SC] = sc_in;
      set_now        = smp_valid ? cond : '0;
      set_now[F_SC]  = sc_in;
   end

   dfg_latch #(.N(NF)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (set_now),
      .live  (live_now),
      .clr   (fault_clr),
      .stat  (fault_stat)
   );

   dfg_brake u_brake (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .over      (cond[F_OV]),
      .below_rel (below_rel),
      .brake_on  (brake_on)
   );

   act_e act;
   dfg_grade u_grade (
      .stat        (fault_stat),
      .sc_now      (sc_in),
      .gate_off    (gate_off),
      .stop_req    (stop_req),
      .torque_zero (torque_zero),
      .derate      (derate),
      .act         (act)
   );

   assign act_code = act;
   assign cur_lim  = fault_stat[F_OTW] ? DW'(thr[T_DER]) : rated_cur;
endmodule

// File: rtl/dfg_checker.sv
module dfg_checker #(
   parameter int NF = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          smp_valid,
   input logic          sc_in,
   input logic          fault_clr,
   input logic [NF-1:0] fault_stat,
   input logic          gate_off,
   input logic          stop_req,
   input logic          torque_zero,
   input logic          derate,
   input logic          brake_on
);
   a_r1_sc_gates: assert property (@(posedge clk) disable iff (!rst_n)
      sc_in |-> gate_off);

   a_r9_one_response: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({gate_off, stop_req, torque_zero, derate}));

   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_clr |=> ((fault_stat & $past(fault_stat)) == $past(fault_stat)));

   a_r10_no_set_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_valid && !sc_in) |=> ((fault_stat & ~$past(fault_stat)) == '0));

   a_r3_brake_rise_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brake_on) |-> $past(smp_valid));

   a_r3_brake_fall_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(brake_on) |-> $past(smp_valid));

   a_r4_stop_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      stop_req |-> (fault_stat[3] || fault_stat[5]));
endmodule

bind drive_fault_guard dfg_checker #(.NF(dfg_pkg::NF)) u_dfg_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .smp_valid   (smp_valid),
   .sc_in       (sc_in),
   .fault_clr   (fault_clr),
   .fault_stat  (fault_stat),
   .gate_off    (gate_off),
   .stop_req    (stop_req),
   .torque_zero (torque_zero),
   .derate      (derate),
   .brake_on    (brake_on)
);

// File: tb/test_drive_fault_guard.sv
`timescale 1ns/1ps
module test_drive_fault_guard;
   localparam int DW = 12;
   localparam int TW = 10;
   localparam int RC = 1000;
   localparam int RV = 2000;
   localparam int RS = 1500;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 smp_valid = 1'b0;
   logic signed [DW-1:0] i_arm = '0;
   logic [DW-1:0]        v_link = '0;
   logic signed [TW-1:0] temp = '0;
   logic signed [DW-1:0] speed = '0;
   logic [DW-1:0]        rated_cur = DW'(RC);
   logic [DW-1:0]        rated_volt = DW'(RV);
   logic [DW-1:0]        rated_spd = DW'(RS);
   logic                 sc_in = 1'b0;
   logic                 fault_clr = 1'b0;
   logic [6:0]           fault_stat;
   logic                 gate_off, stop_req, torque_zero, derate, brake_on;
   logic [DW-1:0]        cur_lim;
   logic [2:0]           act_code;

   always #4 clk = ~clk;

   drive_fault_guard i_drive_fault_guard (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .i_arm(i_arm),
      .v_link(v_link), .temp(temp), .speed(speed), .rated_cur(rated_cur),
      .rated_volt(rated_volt), .rated_spd(rated_spd), .sc_in(sc_in),
      .fault_clr(fault_clr), .fault_stat(fault_stat), .gate_off(gate_off),
      .stop_req(stop_req), .torque_zero(torque_zero), .derate(derate),
      .brake_on(brake_on), .cur_lim(cur_lim), .act_code(act_code)
   );

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   bit [6:0] m_stat = '0;
   bit [6:0] m_live = '0;
   bit       m_brake = 0;

   function automatic int scale(int rated, int k);
      return (rated * k) >>> 6;
   endfunction

   function automatic int iabs(int x);
      return (x < 0) ? -x : x;
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare_all(bit sc_now);
      bit g, st, tz, dr;
      int ac;
      g  = sc_now | m_stat[0] | m_stat[1];
      st = !g && (m_stat[3] || m_stat[5]);
      tz = !g && !st && m_stat[6];
      dr = !g && !st && !tz && m_stat[4];
      ac = g ? 4 : st ? 3 : tz ? 2 : dr ? 1 : 0;
      chk("R8", "fault_stat", int'(fault_stat), int'(m_stat));
      chk("R2", "gate_off", int'(gate_off), int'(g));
      chk("R4", "stop_req", int'(stop_req), int'(st));
      chk("R7", "torque_zero", int'(torque_zero), int'(tz));
      chk("R5", "derate", int'(derate), int'(dr));
      chk("R9", "act_code", int'(act_code), ac);
      chk("R3", "brake_on", int'(brake_on), int'(m_brake));
      chk("R5", "cur_lim", int'(cur_lim), m_stat[4] ? scale(RC, 48) : RC);
   endtask

   task automatic step(bit vld, int iv, int vv, int tv, int sv, bit sc, bit clr);
      bit [6:0] c, set, live;
      @(negedge clk);
      smp_valid = vld; i_arm = DW'(iv); v_link = DW'(vv); temp = TW'(tv);
      speed = DW'(sv); sc_in = sc; fault_clr = clr;
      @(posedge clk);
      c = '0;
      c[1] = iabs(iv) >= scale(RC, 112);
      c[2] = vv >= scale(RV, 77);
      c[3] = vv < scale(RV, 51);
      c[4] = tv >= 85;
      c[5] = tv >= 125;
      c[6] = iabs(sv) >= scale(RS, 77);
      set  = vld ? c : 7'b0;
      live = vld ? c : m_live;
      set[0] = sc; live[0] = sc;
      for (int b = 0; b < 7; b++) begin
         if (set[b]) m_stat[b] = 1'b1;
         else if (clr && !live[b]) m_stat[b] = 1'b0;
      end
      if (vld) begin
         m_live = c;
         if (c[2]) m_brake = 1'b1;
         else if (vv < scale(RV, 74)) m_brake = 1'b0;
      end
      @(negedge clk);
      compare_all(sc);
   endtask

   task automatic nominal(bit clr);
      step(1, 0, RV, 25, 0, 0, clr);
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      chk("R11", "fault_stat", int'(fault_stat), 0);
      chk("R11", "act_code", int'(act_code), 0);
      chk("R11", "gate_off", int'(gate_off), 0);
      chk("R11", "brake_on", int'(brake_on), 0);
      chk("R11", "cur_lim", int'(cur_lim), RC);

      // R10: unstrobed over-range sample has no effect
      step(0, 2000, 3000, 140, 2000, 0, 0);
      chk("R10", "fault_stat idle", int'(fault_stat), 0);
      chk("R10", "brake idle", int'(brake_on), 0);

      // R1: short-circuit alone, gate off in same cycle
      @(negedge clk);
      sc_in = 1'b1;
      #1;
      chk("R1", "gate_off comb", int'(gate_off), 1);
      sc_in = 1'b0;
      step(0, 0, RV, 25, 0, 1, 0);
      chk("R1", "sc latched bit0", int'(fault_stat[0]), 1);
      step(0, 0, RV, 25, 0, 0, 1);
      chk("R8", "sc cleared", int'(fault_stat), 0);

      // R2 and R8: over-current stays while live
      step(1, -1750, RV, 25, 0, 0, 0);
      chk("R2", "oc bit1", int'(fault_stat[1]), 1);
      step(0, 0, RV, 25, 0, 0, 1);
      chk("R8", "clear while live", int'(fault_stat[1]), 1);
      nominal(0);
      chk("R8", "sticky after cond gone", int'(fault_stat[1]), 1);
      nominal(1);
      chk("R8", "clear after cond gone", int'(fault_stat), 0);

      // R3: brake hysteresis walk
      step(1, 0, 2406, 25, 0, 0, 0);
      chk("R3", "brake on", int'(brake_on), 1);
      step(1, 0, 2350, 25, 0, 0, 0);
      chk("R3", "brake held in band", int'(brake_on), 1);
      step(1, 0, 2312, 25, 0, 0, 1);
      chk("R3", "brake held at release", int'(brake_on), 1);
      step(1, 0, 2311, 25, 0, 0, 0);
      chk("R3", "brake released", int'(brake_on), 0);
      nominal(1);

      // R5 and R6: graded temperature
      step(1, 0, RV, 85, 0, 0, 0);
      chk("R5", "derate", int'(derate), 1);
      chk("R5", "cur_lim", int'(cur_lim), 750);
      step(1, 0, RV, 125, 0, 0, 0);
      chk("R6", "stop on hot", int'(stop_req), 1);
      nominal(1);

      // R7 and R9: overspeed vs undervoltage priority
      step(1, 0, RV, 25, -1804, 0, 0);
      chk("R7", "torque zero", int'(torque_zero), 1);
      step(1, 0, 1592, 25, 0, 0, 0);
      chk("R9", "stop wins over tz", int'(act_code), 3);
      chk("R4", "uv bit3", int'(fault_stat[3]), 1);
      nominal(1);

      // random mix
      for (int n = 0; n < 400; n++) begin
         bit vld, sc, clr;
         int iv, vv, tv, sv;
         vld = ($urandom_range(0, 3) != 0);
         sc  = ($urandom_range(0, 31) == 0);
         clr = ($urandom_range(0, 4) == 0);
         iv  = int'($urandom_range(0, 3800)) - 1900;
         vv  = int'($urandom_range(1400, 2600));
         tv  = int'($urandom_range(0, 140)) - 10;
         sv  = int'($urandom_range(0, 4000)) - 2000;
         if ($urandom_range(0, 1) == 0) begin
            iv = iv / 4; vv = RV; tv = 40; sv = sv / 4;
         end
         step(vld, iv, vv, tv, sv, sc, clr);
      end

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule